// File: doc/BRIEF.md
# Preemption Verify Handshake Controller

This controller runs the link-partner handshake that must succeed before a port may transmit preemptable fragments. After a start request, or after the link comes up with the preemptable MAC enabled, it issues verify requests toward the transmit path. The first request goes out at once and the rest follow at a programmable interval counted in clock ticks. The number of tries is bounded. The controller follows the transmit path's "verify sent" reports and the partner's "response received" reports to walk a status code through disabled, initial, verifying, succeeded and failed. When the handshake succeeds, it turns on preemptive transmission and the related interrupt enable at the next interval tick.

The controller also answers the partner's own verify requests by pulsing a send-response request. When verification is switched off, a start request applies the transmit and interrupt enables directly, without any handshake. The controller only raises the send requests; the mPacket contents are built elsewhere. A link-down edge clears both enables and stops the interval timer.

Top module: `pvh_verify_ctrl`

## Requirements
- R1: At most MAX_TRIES (default 3) `send_verify_o` pulses are issued per run. When the interval tick after the last try arrives and the status is still initial (1) or verifying (2), the status becomes failed (4) and no further pulse follows.
- R2: In a run that can be armed, the first `send_verify_o` pulse appears in the second cycle after the start or link-up edge is sampled. Later pulses come every `interval_i` cycles, and an interval of 0 behaves as 1.
- R3: A sampled `tx_verify_done_i` with the pMAC enabled sets the status to verifying (2) unless it is succeeded (3).
- R4: A sampled `rx_response_i` with the pMAC enabled sets the status to succeeded (3) only when the status is verifying (2), either already or through a `tx_verify_done_i` sampled in the same cycle. In any other status it is ignored.
- R5: A sampled `rx_verify_i` with `pmac_en_i` high gives one `send_response_o` pulse in the next cycle, whatever the status.
- R6: At the first interval tick that finds the status succeeded, `preempt_tx_en_o` and `irq_en_o` go to 1 and the timer stops, so no further verify pulses follow.
- R7: A start request with `verify_en_i` low sets `preempt_tx_en_o` to `tx_en_i` and `irq_en_o` to `pmac_en_i` in the next cycle and leaves the status unchanged.
- R8: A falling edge of `link_up_i` clears both enables and stops the timer. A rising edge with `pmac_en_i` high clears `preempt_tx_en_o`, sets `irq_en_o`, and acts as a start request. If `verify_en_i` is high, this restarts verification from initial (1) with a full try count.
- R9: While `pmac_en_i` is low, the three event inputs change neither the status nor `send_response_o`.
- R10: After reset the status is disabled (0) and every output is 0.
- R11: A start request with `verify_en_i` high sets the status to initial (1). The timer is armed only if `pmac_en_i`, `tx_en_i` and `link_up_i` are all high; otherwise no verify pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| start_i | input | 1 | Pulse: apply the current configuration |
| link_up_i | input | 1 | Link status level |
| pmac_en_i | input | 1 | Preemptable MAC enabled |
| tx_en_i | input | 1 | Preemptive transmission requested |
| verify_en_i | input | 1 | Handshake required before enabling |
| rx_verify_i | input | 1 | Pulse: verify mPacket received from partner |
| rx_response_i | input | 1 | Pulse: response mPacket received from partner |
| tx_verify_done_i | input | 1 | Pulse: local verify mPacket transmitted |
| interval_i | input | CNT_W | Clock ticks between verify tries |
| send_verify_o | output | 1 | Pulse: request a verify mPacket |
| send_response_o | output | 1 | Pulse: request a response mPacket |
| status_o | output | 3 | 0 disabled, 1 initial, 2 verifying, 3 succeeded, 4 failed |
| preempt_tx_en_o | output | 1 | Final enable for preemptive transmission |
| irq_en_o | output | 1 | Preemption interrupt enable |

## Verification
The handshake is driven through several patterns. A silent partner shows that tries are counted and that the run ends in failure. A normal partner shows the path through verifying to succeeded, with the enables raised at the tick. A response arriving before any verify was sent shows that success depends on the current state. The other patterns are a zero interval, a run that cannot be armed, pMAC-disabled event storms, link flaps and the direct path with verification off. Together they separate interval-spacing errors from try-count errors, and response gating from status gating. A behavioural model in the bench predicts every output on every cycle, and directed checks name each requirement.

// File: rtl/pvh_pkg.sv
package pvh_pkg;

   localparam int unsigned STATUS_W = 3;

   typedef enum logic [STATUS_W-1:0] {
      ST_OFF       = 3'd0,
      ST_INIT      = 3'd1,
      ST_VERIFYING = 3'd2,
      ST_DONE      = 3'd3,
      ST_FAILED    = 3'd4
   } pvh_status_e;

   function automatic logic pvh_is_active(pvh_status_e s);
      return (s == ST_INIT) || (s == ST_VERIFYING);
   endfunction

endpackage

// File: rtl/pvh_interval_timer.sv
module pvh_interval_timer #(
   parameter int unsigned CNT_W       = 24,
   parameter bit          ZERO_AS_ONE = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             arm_i,      // fire on the next cycle
   input  logic             stop_i,     // disarm
   input  logic             rearm_i,    // reload when firing
   input  logic [CNT_W-1:0] interval_i,
   output logic             fire_o
);

   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload;

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("pvh_interval_timer: CNT_W must be at least 1");
      end
      if (ZERO_AS_ONE) begin : g_zero_one
         always_comb begin
            if (interval_i == '0) reload = '0;
            else                  reload = interval_i - 1'b1;
         end
      end else begin : g_zero_wrap
         always_comb reload = interval_i - 1'b1;
      end
   endgenerate

   assign fire_o = armed_q && (cnt_q == '0) && !arm_i && !stop_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (arm_i) begin
         armed_q <= 1'b1;
         cnt_q   <= '0;
      end else if (stop_i) begin
         armed_q <= 1'b0;
      end else if (fire_o) begin
         if (rearm_i) cnt_q <= reload;
         else         armed_q <= 1'b0;
      end else if (armed_q) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   AST_ARM_FIRES_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arm_i |=> (fire_o || arm_i || stop_i)) else $error("arm did not lead to a fire"); // R2

endmodule

// File: rtl/pvh_try_counter.sv
module pvh_try_counter #(
   parameter int unsigned MAX_TRIES = 3,
   localparam int unsigned TRY_W    = $clog2(MAX_TRIES + 1)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic load_i,
   input  logic take_i,
   output logic avail_o
);

   logic [TRY_W-1:0] left_q;

   generate
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("pvh_try_counter: MAX_TRIES must be at least 1");
      end
   endgenerate

   assign avail_o = (left_q != '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     left_q <= '0;
      else if (load_i) left_q <= TRY_W'(MAX_TRIES);
      else if (take_i) left_q <= left_q - 1'b1;
   end

   AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_i && !load_i) |-> avail_o) else $error("try taken with none left"); // R1

endmodule

// File: rtl/pvh_event_unit.sv
module pvh_event_unit
   import pvh_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        pmac_en_i,
   input  logic        rx_verify_i,
   input  logic        rx_response_i,
   input  logic        tx_verify_done_i,
   input  pvh_status_e cur_i,
   output pvh_status_e nxt_o,
   output logic        send_response_o
);

   pvh_status_e after_tx;

   // tx report is applied first, so a response in the same cycle sees it
   always_comb begin
      after_tx = cur_i;
      if (pmac_en_i && tx_verify_done_i && (cur_i != ST_DONE)) after_tx = ST_VERIFYING;
      nxt_o = after_tx;
      if (pmac_en_i && rx_response_i && (after_tx == ST_VERIFYING)) nxt_o = ST_DONE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) send_response_o <= 1'b0;
      else         send_response_o <= pmac_en_i && rx_verify_i;
   end

   AST_RESP_NEEDS_PMAC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      send_response_o |-> $past(rx_verify_i && pmac_en_i)) else $error("unrequested response"); // R5

endmodule

// File: rtl/pvh_verify_ctrl.sv
module pvh_verify_ctrl
   import pvh_pkg::*;
#(
   parameter int unsigned CNT_W       = 24,
   parameter int unsigned MAX_TRIES   = 3,
   parameter bit          ZERO_AS_ONE = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             link_up_i,
   input  logic             pmac_en_i,
   input  logic             tx_en_i,
   input  logic             verify_en_i,
   input  logic             rx_verify_i,
   input  logic             rx_response_i,
   input  logic             tx_verify_done_i,
   input  logic [CNT_W-1:0] interval_i,
   output logic             send_verify_o,
   output logic             send_response_o,
   output logic [2:0]       status_o,
   output logic             preempt_tx_en_o,
   output logic             irq_en_o
);

   pvh_status_e status_q, status_ev, status_d;
   logic link_q;
   logic link_rise, link_fall, apply, apply_hs, apply_direct;
   logic arm, stop, fire, try_ok, take, give_up, enable_now;
   logic pe_d, irq_d;

   generate
      if (STATUS_W != 3) begin : g_bad_status
         $error("pvh_verify_ctrl: status port expects 3 bits");
      end
   endgenerate

   // ---- edge and request decode ----
   assign link_rise    = link_up_i && !link_q;
   assign link_fall    = !link_up_i && link_q;
   assign apply        = start_i || (link_rise && pmac_en_i);
   assign apply_hs     = apply && verify_en_i;
   assign apply_direct = apply && !verify_en_i;
   assign arm          = apply_hs && pmac_en_i && tx_en_i && link_up_i;
   assign stop         = link_rise || link_fall || apply_hs;

   // ---- timer tick actions ----
   assign take       = fire && pvh_is_active(status_q) && try_ok;
   assign give_up    = fire && pvh_is_active(status_q) && !try_ok;
   assign enable_now = fire && (status_q == ST_DONE);

   pvh_interval_timer #(
      .CNT_W       (CNT_W),
      .ZERO_AS_ONE (ZERO_AS_ONE)
   ) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .arm_i      (arm),
      .stop_i     (stop),
      .rearm_i    (take),
      .interval_i (interval_i),
      .fire_o     (fire)
   );

   pvh_try_counter #(
      .MAX_TRIES (MAX_TRIES)
   ) u_tries (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (apply_hs),
      .take_i  (take),
      .avail_o (try_ok)
   );

   pvh_event_unit u_events (
      .clk_i            (clk_i),
      .rst_ni           (rst_ni),
      .pmac_en_i        (pmac_en_i),
      .rx_verify_i      (rx_verify_i),
      .rx_response_i    (rx_response_i),
      .tx_verify_done_i (tx_verify_done_i),
      .cur_i            (status_q),
      .nxt_o            (status_ev),
      .send_response_o  (send_response_o)
   );

   // ---- next status ----
   always_comb begin
      if (apply_hs)     status_d = ST_INIT;
      else if (give_up) status_d = ST_FAILED;
      else              status_d = status_ev;
   end

   // ---- enables: link handling, then configuration request, then tick ----
   always_comb begin
      pe_d  = preempt_tx_en_o;
      irq_d = irq_en_o;
      if (link_fall) begin
         pe_d  = 1'b0;
         irq_d = 1'b0;
      end else if (link_rise) begin
         pe_d  = 1'b0;
         irq_d = pmac_en_i;
      end
      if (apply_direct) begin
         pe_d  = tx_en_i;
         irq_d = pmac_en_i;
      end else if (enable_now) begin
         pe_d  = 1'b1;
         irq_d = 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         status_q        <= ST_OFF;
         link_q          <= 1'b0;
         send_verify_o   <= 1'b0;
         preempt_tx_en_o <= 1'b0;
         irq_en_o        <= 1'b0;
      end else begin
         status_q        <= status_d;
         link_q          <= link_up_i;
         send_verify_o   <= take;
         preempt_tx_en_o <= pe_d;
         irq_en_o        <= irq_d;
      end
   end

   assign status_o = status_q;

   AST_NO_SEND_WHEN_FAILED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      send_verify_o |-> (status_q != ST_FAILED)) else $error("verify sent in failed state"); // R1

   AST_VERIFYING_NEEDS_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_q == ST_VERIFYING && $past(status_q) != ST_VERIFYING)
         |-> $past(tx_verify_done_i && pmac_en_i)) else $error("verifying without tx report"); // R3

   AST_DONE_NEEDS_RESPONSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_q == ST_DONE && $past(status_q) != ST_DONE)
         |-> $past(rx_response_i && pmac_en_i)) else $error("success without response"); // R4

   AST_LINK_DOWN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (link_q && !link_up_i && !start_i) |=> (!preempt_tx_en_o && !irq_en_o))
      else $error("enables survived link down"); // R8

   AST_STATUS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o <= 3'd4) else $error("illegal status code"); // R10

endmodule

// File: tb/pvh_verify_ctrl_tb.sv
module pvh_verify_ctrl_tb;

   localparam int CW = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 0, link = 0, pmac = 0, txen = 0, ven = 0;
   logic rxv = 0, rxr = 0, txd = 0;
   logic [CW-1:0] ivl = 24'd5;
   logic sv, sr, pe, irq;
   logic [2:0] st;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // reference model state
   int m_status = 0, m_tries = 0, m_cnt = 0;
   bit m_armed = 0, m_pe = 0, m_irq = 0, m_sv = 0, m_sr = 0, m_link = 0;

   always #5 clk = ~clk;

   pvh_verify_ctrl u_dut (
      .clk_i (clk), .rst_ni (rst_n), .start_i (start), .link_up_i (link),
      .pmac_en_i (pmac), .tx_en_i (txen), .verify_en_i (ven),
      .rx_verify_i (rxv), .rx_response_i (rxr), .tx_verify_done_i (txd),
      .interval_i (ivl), .send_verify_o (sv), .send_response_o (sr),
      .status_o (st), .preempt_tx_en_o (pe), .irq_en_o (irq));

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // behavioural model of the requirements
   always @(posedge clk) begin
      if (!rst_n) begin
         m_status = 0; m_tries = 0; m_cnt = 0; m_armed = 0;
         m_pe = 0; m_irq = 0; m_sv = 0; m_sr = 0; m_link = 0;
      end else begin
         bit rise, fall, app, arm, stp, fire, act, snd, fl, dn;
         int es, ns;
         rise = link && !m_link;
         fall = !link && m_link;
         app  = start || (rise && pmac);
         arm  = app && ven && pmac && txen && link;
         stp  = rise || fall || (app && ven);
         fire = m_armed && m_cnt == 0 && !arm && !stp;
         act  = (m_status == 1) || (m_status == 2);
         snd  = fire && act && m_tries > 0;
         fl   = fire && act && m_tries == 0;
         dn   = fire && m_status == 3;
         es = m_status;
         if (pmac && txd && es != 3) es = 2;
         if (pmac && rxr && es == 2) es = 3;
         if (app && ven) ns = 1; else if (fl) ns = 4; else ns = es;
         if (fall) begin m_pe = 0; m_irq = 0; end
         else if (rise) begin m_pe = 0; m_irq = pmac; end
         if (app && !ven) begin m_pe = txen; m_irq = pmac; end
         else if (dn) begin m_pe = 1; m_irq = 1; end
         if (app && ven) m_tries = 3; else if (snd) m_tries--;
         if (arm) begin m_armed = 1; m_cnt = 0; end
         else if (stp) m_armed = 0;
         else if (fire) begin
            if (snd) m_cnt = ((ivl == 0) ? 1 : int'(ivl)) - 1;
            else m_armed = 0;
         end else if (m_armed) m_cnt--;
         m_status = ns; m_sv = snd; m_sr = pmac && rxv; m_link = link;
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 send_verify", sv, m_sv);
         chk("R5 send_response", sr, m_sr);
         chk("R3 status", st, m_status);
         chk("R6 preempt_tx_en", pe, m_pe);
         chk("R6 irq_en", irq, m_irq);
      end
   end

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
         finish_run();
      end
   end

   initial begin
      int n, gap, last;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R10 reset state
      chk("R10 status", st, 0);
      chk("R10 outputs", {sv, sr, pe, irq}, 0);

      // silent partner via link-up restart: R8, R2, R1
      pmac = 1; txen = 1; ven = 1; ivl = 5;
      link = 1;
      tick(1);
      chk("R8 restart status", st, 1);
      chk("R8 irq on link up", irq, 1);
      chk("R2 no pulse yet", sv, 0);
      tick(1);
      chk("R2 first pulse", sv, 1);
      n = 1; last = 0; gap = 0;
      for (int i = 1; i <= 25; i++) begin
         tick(1);
         if (sv) begin n++; if (gap == 0) gap = i; end
      end
      chk("R2 interval spacing", gap, 5);
      chk("R1 try count", n, 3);
      chk("R1 failed", st, 4);

      // normal partner: R11, R4, R3, R6
      start = 1; tick(1); start = 0;
      chk("R11 initial", st, 1);
      tick(1);
      chk("R2 first pulse after start", sv, 1);
      rxr = 1; tick(1); rxr = 0;
      chk("R4 response ignored in initial", st, 1);
      txd = 1; tick(1); txd = 0;
      chk("R3 verifying", st, 2);
      rxr = 1; tick(1); rxr = 0;
      chk("R4 succeeded", st, 3);
      chk("R6 not yet enabled", pe, 0);
      last = 0;
      for (int i = 0; i < 8; i++) begin tick(1); if (pe && last == 0) last = 1; end
      chk("R6 preempt enabled", pe, 1);
      chk("R6 irq enabled", irq, 1);
      n = 0;
      for (int i = 0; i < 20; i++) begin tick(1); if (sv) n++; end
      chk("R6 timer stopped", n, 0);

      // partner verify answered: R5
      rxv = 1; tick(1); rxv = 0;
      chk("R5 response pulse", sr, 1);
      tick(1);
      chk("R5 single pulse", sr, 0);

      // link down: R8
      link = 0; tick(1);
      chk("R8 preempt off", pe, 0);
      chk("R8 irq off", irq, 0);

      // pMAC disabled: R9, R11 (not armed)
      tick(2);
      pmac = 0; link = 1; tick(1);
      start = 1; tick(1); start = 0;
      chk("R11 initial unarmed", st, 1);
      txd = 1; rxv = 1; tick(1); txd = 0; rxv = 0; rxr = 1;
      chk("R9 tx report ignored", st, 1);
      tick(1); rxr = 0;
      chk("R9 no response", sr, 0);
      chk("R9 status held", st, 1);
      n = 0;
      for (int i = 0; i < 12; i++) begin tick(1); if (sv) n++; end
      chk("R11 no verify when unarmed", n, 0);

      // tx disabled also blocks arming: R11
      pmac = 1; txen = 0; start = 1; tick(1); start = 0;
      n = 0;
      for (int i = 0; i < 12; i++) begin tick(1); if (sv) n++; end
      chk("R11 tx_en low unarmed", n, 0);

      // direct apply without handshake: R7
      ven = 0; txen = 1; start = 1; tick(1); start = 0;
      chk("R7 preempt direct", pe, 1);
      chk("R7 irq direct", irq, 1);
      chk("R7 status unchanged", st, 1);
      txen = 0; start = 1; tick(1); start = 0;
      chk("R7 preempt follows tx_en", pe, 0);

      // zero interval behaves as one: R2, R1
      ven = 1; txen = 1; ivl = 0;
      start = 1; tick(1); start = 0;
      tick(1); chk("R2 zero ivl pulse 1", sv, 1);
      tick(1); chk("R2 zero ivl pulse 2", sv, 1);
      tick(1); chk("R2 zero ivl pulse 3", sv, 1);
      tick(1); chk("R1 zero ivl no fourth", sv, 0);
      chk("R1 zero ivl failed", st, 4);

      // tx report after failure returns to verifying: R3
      txd = 1; tick(1); txd = 0;
      chk("R3 from failed", st, 2);
      // same-cycle tx report and response: R4
      start = 1; tick(1); start = 0;
      txd = 1; rxr = 1; tick(1); txd = 0; rxr = 0;
      chk("R4 same-cycle success", st, 3);
      tick(4);
      finish_run();
   end

endmodule